// File: doc/BRIEF.md
# Byte-Strobe SRAM Bus Controller

This controller sits between an internal requester and an external asynchronous SRAM with a 16-bit data path and separate upper and lower byte-select strobes. The requester presents a byte address, a direction and a transfer size: a single byte, a 16-bit halfword, or a 32-byte cache line. The controller then drives chip select, a read strobe, the two byte strobes, the halfword address and the write data, all timed to the bus clock.

The byte strobes work in both directions. In a write cycle they are ordinary per-byte write enables. In a read cycle, only the strobes of the lanes being read go low. A strobe goes low on a falling clock edge and returns high on the rising edge where the read strobe ends. A line transfer is split into sixteen halfword beats. The first beat fetches the requested halfword, and later beats wrap within the aligned 32-byte block. The bus is held for the whole line. A mode input, used when the region runs as a multiplexed address/data bus, keeps the byte strobes idle during reads.

Top module: `bsram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, chip select, read strobe and both byte strobes are high, the data bus is not driven, and a request is accepted (ready high).
- R2: An accepted request starts on the next rising edge. Each beat holds chip select low for exactly ACC_CYC clocks with the halfword address (byte address shifted right by one) stable. After a request, chip select returns high for at least one clock.
- R3: In a read, the read strobe is high in the first clock of each beat and low for the remaining ACC_CYC-1 clocks. It rises on the rising edge that ends the beat.
- R4: A byte strobe that is used goes low on the falling edge in the middle of the second clock of the beat. It rises on the same rising edge as the read strobe, so it is high in the first clock of every beat and in the first half of the second.
- R5: Lane choice: strobe bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A byte access (size code 0) uses bit 0 when address bit 0 is 0 and bit 1 when it is 1. A halfword access (size code 1) and a line access (size code 2) use both.
- R6: In a write, the read strobe stays high, the data bus is driven for the whole beat, and the byte strobes follow the R4 timing. A byte write places write-data bits 7:0 on both lanes.
- R7: Read data is sampled on the rising edge that ends each read beat. It is returned on the read-data output with the valid flag high for exactly one clock after that edge, one pulse per beat in access order.
- R8: A line access performs 16 beats. Beat k uses the halfword index (start + k) mod 16, where start is address bits 4:1, and the upper address bits stay fixed.
- R9: Chip select stays low with no gap across all 16 beats of a line, and ready stays low until the line ends.
- R10: While the multiplexed-mode input is high, both byte strobes stay high during reads. Writes still drive them.
- R11: The write-data input is taken, with the take flag high, in the cycle a write request is accepted and in the last clock of every line-write beat except the last. Each beat drives the data taken before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 line |
| req_addr_i | input | AW | Byte address |
| wdata_i | input | 16 | Write data for the current beat |
| wtake_o | output | 1 | Write data taken this cycle |
| rdata_o | output | 16 | Returned read beat |
| rvalid_o | output | 1 | Read beat valid, one clock |
| mux_mode_i | input | 1 | Multiplexed-mode region, byte strobes idle on reads |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_rd_n_o | output | 1 | Read strobe, active low |
| mem_bs_n_o | output | 2 | Byte strobes, active low, bit 1 upper |
| mem_addr_o | output | AW-1 | Halfword address |
| mem_dq_o | output | 16 | Write data to memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Read data from memory |

## Verification
A wrong phase or beat count shows up within one clock as a strobe edge in the wrong half-cycle or a chip-select gap. That is why the bench samples every output once in each half of every clock. A bad wrap count shows up as a wrong address on the first beat after the wrap point. A corrupt lane mask shows up in the second half of the second clock of the beat, when the strobes first go low. A lost capture shows up one clock after the beat as a missing or wrong read pulse.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int BUS_BYTES  = 2;
    localparam int LANE_W     = 8;
    localparam int DQ_W       = BUS_BYTES * LANE_W;
    localparam int LINE_BYTES = 32;
    localparam int LINE_BEATS = LINE_BYTES / BUS_BYTES;
    localparam int BEAT_W     = $clog2(LINE_BEATS);
    localparam int OFF_W      = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LINE = 2'd2
    } xfer_size_e;

    // lanes touched by an access; bit 0 is data[7:0]
    function automatic logic [BUS_BYTES-1:0] lane_sel(xfer_size_e sz, logic a0);
        logic [BUS_BYTES-1:0] m;
        if (sz == SZ_BYTE) m = a0 ? 2'b10 : 2'b01;
        else               m = '1;
        return m;
    endfunction

    // halfword index within the line for a given beat, wrapping
    function automatic logic [BEAT_W-1:0] wrap_idx(logic [BEAT_W-1:0] start,
                                                   logic [BEAT_W-1:0] beat);
        return start + beat;
    endfunction

    // place write data on the lanes
    function automatic logic [DQ_W-1:0] lane_pack(xfer_size_e sz, logic [DQ_W-1:0] d);
        logic [DQ_W-1:0] r;
        if (sz == SZ_BYTE) r = {d[LANE_W-1:0], d[LANE_W-1:0]};
        else               r = d;
        return r;
    endfunction

endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int AW      = 24,
    parameter int ACC_CYC = 3,
    localparam int PH_W   = $clog2(ACC_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  xfer_size_e        req_size,
    input  logic [AW-1:0]     req_addr,
    output logic              accept,
    output logic              busy,
    output logic              wr,
    output xfer_size_e        size,
    output logic [AW-1:0]     addr,
    output logic [PH_W-1:0]   ph,
    output logic [BEAT_W-1:0] beat,
    output logic              beat_end,
    output logic              more_beats
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(ACC_CYC - 1);

    logic [BEAT_W-1:0] last_beat;

    assign last_beat  = (size == SZ_LINE) ? BEAT_W'(LINE_BEATS - 1) : '0;
    assign accept     = req_valid && !busy;
    assign beat_end   = busy && (ph == LAST_PH);
    assign more_beats = (beat != last_beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            wr   <= 1'b0;
            size <= SZ_BYTE;
            addr <= '0;
            ph   <= '0;
            beat <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy <= 1'b1;
                wr   <= req_write;
                size <= req_size;
                addr <= req_addr;
                ph   <= '0;
                beat <= '0;
            end
        end else if (ph == LAST_PH) begin
            ph <= '0;
            if (more_beats) beat <= beat + 1'b1;
            else            busy <= 1'b0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

endmodule

// File: rtl/bsram_addr.sv
module bsram_addr
    import bsram_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0]        addr,
    input  xfer_size_e           size,
    input  logic [BEAT_W-1:0]    beat,
    output logic [AW-2:0]        mem_addr,
    output logic [BUS_BYTES-1:0] lane_mask
);
    always_comb begin
        if (size == SZ_LINE)
            mem_addr = {addr[AW-1:OFF_W], wrap_idx(addr[OFF_W-1:1], beat)};
        else
            mem_addr = addr[AW-1:1];
        lane_mask = lane_sel(size, addr[0]);
    end

endmodule

// File: rtl/bsram_strobe.sv
module bsram_strobe
    import bsram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win,
    input  logic                 en,
    input  logic [BUS_BYTES-1:0] lane_mask,
    output logic [BUS_BYTES-1:0] bs_n
);
    // window seen at the falling edge: assert late, release with the window
    logic fall_q;
    logic act;

    always_ff @(negedge clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= win;
    end

    assign act = fall_q && win && en;

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        assign bs_n[i] = ~(lane_mask[i] && act);
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW      = 24,
    parameter int ACC_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic                 req_write_i,
    input  logic [1:0]           req_size_i,
    input  logic [AW-1:0]        req_addr_i,
    input  logic [DQ_W-1:0]      wdata_i,
    output logic                 wtake_o,
    output logic [DQ_W-1:0]      rdata_o,
    output logic                 rvalid_o,
    input  logic                 mux_mode_i,
    output logic                 mem_cs_n_o,
    output logic                 mem_rd_n_o,
    output logic [BUS_BYTES-1:0] mem_bs_n_o,
    output logic [AW-2:0]        mem_addr_o,
    output logic [DQ_W-1:0]      mem_dq_o,
    output logic                 mem_dq_oe_o,
    input  logic [DQ_W-1:0]      mem_dq_i
);
    localparam int PH_W = $clog2(ACC_CYC);

    logic                 accept, busy, wr, beat_end, more_beats;
    xfer_size_e           size;
    logic [AW-1:0]        addr;
    logic [PH_W-1:0]      ph;
    logic [BEAT_W-1:0]    beat;
    logic [BUS_BYTES-1:0] lane_mask;
    logic                 win, next_wbeat;
    logic [DQ_W-1:0]      wdata_q, rdata_q;
    logic                 rvalid_q;

    bsram_seq #(.AW(AW), .ACC_CYC(ACC_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid_i),
        .req_write  (req_write_i),
        .req_size   (xfer_size_e'(req_size_i)),
        .req_addr   (req_addr_i),
        .accept     (accept),
        .busy       (busy),
        .wr         (wr),
        .size       (size),
        .addr       (addr),
        .ph         (ph),
        .beat       (beat),
        .beat_end   (beat_end),
        .more_beats (more_beats)
    );

    bsram_addr #(.AW(AW)) u_addr (
        .addr      (addr),
        .size      (size),
        .beat      (beat),
        .mem_addr  (mem_addr_o),
        .lane_mask (lane_mask)
    );

    assign win = busy && (ph != '0);

    bsram_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .win       (win),
        .en        (wr || !mux_mode_i),
        .lane_mask (lane_mask),
        .bs_n      (mem_bs_n_o)
    );

    assign next_wbeat = beat_end && more_beats && wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept && req_write_i)
                wdata_q <= lane_pack(xfer_size_e'(req_size_i), wdata_i);
            else if (next_wbeat)
                wdata_q <= wdata_i;
            if (beat_end && !wr)
                rdata_q <= mem_dq_i;
            rvalid_q <= beat_end && !wr;
        end
    end

    assign req_ready_o = !busy;
    assign wtake_o     = (accept && req_write_i) || next_wbeat;
    assign mem_cs_n_o  = !busy;
    assign mem_rd_n_o  = !(win && !wr);
    assign mem_dq_oe_o = busy && wr;
    assign mem_dq_o    = wdata_q;
    assign rdata_o     = rdata_q;
    assign rvalid_o    = rvalid_q;

endmodule

// File: rtl/bsram_ctrl_chk.sv
module bsram_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mux_mode_i,
    input logic       req_ready_o,
    input logic       rvalid_o,
    input logic       mem_cs_n_o,
    input logic       mem_rd_n_o,
    input logic [1:0] mem_bs_n_o,
    input logic       mem_dq_oe_o
);
    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (mem_cs_n_o && mem_rd_n_o && mem_bs_n_o == 2'b11 && !mem_dq_oe_o));

    // R6: never read and drive together
    p_read_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n_o |-> !mem_dq_oe_o);

    // R4: strobes only inside chip select
    p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_bs_n_o != 2'b11) |-> !mem_cs_n_o);

    // R4: strobes released by the edge that ends the read strobe
    p_strobe_release_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_n_o) |-> (mem_bs_n_o == 2'b11));

    // R10
    p_mux_read_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mux_mode_i && !mem_rd_n_o) |-> (mem_bs_n_o == 2'b11));

    // R7
    p_rvalid_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> $past(!mem_rd_n_o));

    // R9: chip select only starts from idle
    p_cs_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n_o) |-> $past(req_ready_o));

endmodule

bind bsram_ctrl bsram_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mux_mode_i  (mux_mode_i),
    .req_ready_o (req_ready_o),
    .rvalid_o    (rvalid_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_rd_n_o  (mem_rd_n_o),
    .mem_bs_n_o  (mem_bs_n_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/bsram_ctrl_bench.sv
module bsram_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 24;
    localparam int ACC_CYC    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, mux_mode = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   wdata = '0;
    logic          req_ready, wtake, rvalid, cs_n, rd_n, dq_oe;
    logic [15:0]   rdata, dq_o, dq_i;
    logic [1:0]    bs_n;
    logic [AW-2:0] mem_addr;

    int  vec = 0;
    int  bad = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_word(logic [AW-2:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h03};
    endfunction

    assign dq_i = mem_word(mem_addr);

    bsram_ctrl #(.AW(AW), .ACC_CYC(ACC_CYC)) u_bsram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_size_i(req_size), .req_addr_i(req_addr), .wdata_i(wdata),
        .wtake_o(wtake), .rdata_o(rdata), .rvalid_o(rvalid), .mux_mode_i(mux_mode),
        .mem_cs_n_o(cs_n), .mem_rd_n_o(rd_n), .mem_bs_n_o(bs_n), .mem_addr_o(mem_addr),
        .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // starts at a falling-edge sample point with the controller idle
    task automatic do_req(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                          input bit mx, input logic [15:0] seed);
        int nbeats;
        logic [1:0]    bsx;
        logic [AW-2:0] ea, prev_a;
        logic [15:0]   ew;
        nbeats = (sz == 2'd2) ? 16 : 1;
        if (!wr && mx)       bsx = 2'b11;
        else if (sz == 2'd0) bsx = a[0] ? 2'b01 : 2'b10;
        else                 bsx = 2'b00;
        mux_mode = mx; req_write = wr; req_size = sz; req_addr = a; wdata = seed;
        req_valid = 1'b1;
        #1;
        chk("R11 take at accept", wtake, wr);
        prev_a = '0;
        for (int b = 0; b < nbeats; b++) begin
            if (sz == 2'd2) ea = {a[AW-1:5], 4'(a[4:1] + b)};
            else            ea = a[AW-1:1];
            if (sz == 2'd0) ew = {seed[7:0], seed[7:0]};
            else            ew = seed + 16'(b * 16'h1111);
            for (int k = 0; k < ACC_CYC; k++) begin
                @(posedge clk); #2;
                if (b == 0 && k == 0) req_valid = 1'b0;
                chk("R2/R9 cs low", cs_n, 1'b0);
                chk("R9 ready low", req_ready, 1'b0);
                chk("R2/R8 address", mem_addr, ea);
                chk("R3 read strobe", rd_n, (!wr && k >= 1) ? 1'b0 : 1'b1);
                chk("R4/R5/R10 strobe first half", bs_n, (k >= 2) ? bsx : 2'b11);
                chk("R6 drive", dq_oe, wr);
                if (wr) chk("R6/R11 write data", dq_o, ew);
                chk("R7 rvalid", rvalid, (!wr && k == 0 && b > 0));
                if (!wr && k == 0 && b > 0) chk("R7 rdata", rdata, mem_word(prev_a));
                chk("R11 take", wtake, (wr && k == ACC_CYC-1 && b < nbeats-1));
                @(negedge clk); #2;
                chk("R4/R5/R10 strobe second half", bs_n, (k >= 1) ? bsx : 2'b11);
                if (wr && k == ACC_CYC-1 && b < nbeats-1)
                    wdata = seed + 16'((b + 1) * 16'h1111);
            end
            prev_a = ea;
        end
        @(posedge clk); #2;
        chk("R2 cs released", cs_n, 1'b1);
        chk("R9 ready back", req_ready, 1'b1);
        chk("R3 read strobe idle", rd_n, 1'b1);
        chk("R4 strobes idle", bs_n, 2'b11);
        chk("R7 last rvalid", rvalid, !wr);
        if (!wr) chk("R7 last rdata", rdata, mem_word(prev_a));
        @(negedge clk); #2;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        chk("R1 cs", cs_n, 1'b1);
        chk("R1 rd", rd_n, 1'b1);
        chk("R1 bs", bs_n, 2'b11);
        chk("R1 oe", dq_oe, 1'b0);
        chk("R1 ready", req_ready, 1'b1);
        chk("R1 rvalid", rvalid, 1'b0);
        @(negedge clk); #2;
        rst = 1'b0;
        do_req(0, 2'd1, 24'h000124, 0, 16'h0000);   // R3 R4 R5 half read
        do_req(0, 2'd0, 24'h000125, 0, 16'h0000);   // R5 odd byte read
        do_req(0, 2'd0, 24'h000126, 0, 16'h0000);   // R5 even byte read
        do_req(1, 2'd0, 24'h000341, 0, 16'h12AB);   // R6 odd byte write
        do_req(1, 2'd1, 24'h000342, 0, 16'hBEEF);   // R6 half write
        do_req(0, 2'd2, 24'h00213A, 0, 16'h0000);   // R8 wrap from index 13
        do_req(1, 2'd2, 24'h00400A, 0, 16'h1000);   // R8 R11 line write from 5
        do_req(0, 2'd2, 24'h005000, 0, 16'h0000);   // R8 aligned line
        do_req(0, 2'd0, 24'h000127, 1, 16'h0000);   // R10 quiet read
        do_req(0, 2'd1, 24'h000128, 1, 16'h0000);   // R10 quiet half read
        do_req(1, 2'd0, 24'h000130, 1, 16'h00C3);   // R10 writes still strobe
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule